// File: doc/BRIEF.md
# Three-Lane Seven-to-One Serial Deserializer

This block rebuilds a 21-bit parallel word from three serial lanes. Each lane carries seven bits per frame. A fast clock at seven times the frame rate samples the lanes, the frame clock and the power control. The frame clock travels alongside the data and is read as an ordinary sampled signal. The cycle in which it is first seen high marks the start of a frame. From that cycle on, one bit per lane is taken in each of seven consecutive fast cycles.

A completed frame moves through a two-stage pipeline that advances on frame edges. Each word therefore reaches the output two frame periods after its own edge. A registered output strobe rises while the word is steady, and that rising edge marks valid data. An active-low power control, the loss of the frame clock and a restart after either of them all have defined effects on the word and on the strobe.

Top module: `tri_lane_deser`

## Requirements
- R1: Bit i of lane L (i = 0..6, where i is the sample order) appears on word_o[7*L + i]. Lane 0 fills bits 0 to 6, lane 1 fills bits 7 to 13 and lane 2 fills bits 14 to 20.
- R2: A frame edge is a cycle in which frame_clk_i is sampled high after being sampled low in the previous cycle. Sample 0 is taken in the edge cycle and samples 1 to 6 in the six cycles that follow. Lane values in later cycles, before the next edge, do not change the word.
- R3: strobe_o is high during sample positions 3 to 6 of each frame and low for the rest of the frame. word_o changes only while strobe_o is low, so a rising edge of strobe_o marks a valid word.
- R4: The word from the frame whose edge is sampled at clock edge E is on word_o after clock edge E+14. The rising edge of strobe_o for that word follows clock edge E+17.
- R5: If pwr_on_n_i is sampled low, word_o and strobe_o are 0 after that clock edge. This takes priority over a frame edge or an output update in the same cycle, and frames already in flight are dropped.
- R6: After power-on, word_o and strobe_o stay low until two complete frames have been captured. The first word delivered is the first frame whose edge comes after pwr_on_n_i went high.
- R7: If no frame edge is seen in 16 consecutive cycles (a frame period of 17 cycles or more), the clock is treated as lost. word_o keeps its last word, strobe_o stays low and frames in flight are dropped. A period of 16 cycles loses no frames.
- R8: After a loss, capture starts again at the next frame edge. That frame is delivered two frames later, with no strobe for any word from before the loss.
- R9: If the frame clock runs while every lane is held high, word_o becomes all ones.
- R10: After reset, word_o is 0 and strobe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, seven times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk_i | input | 1 | Frame clock, sampled in the fast clock domain |
| lane_i | input | 3 | Serial data lanes, one bit per fast cycle |
| pwr_on_n_i | input | 1 | Active-low power control; low forces the outputs low |
| word_o | output | 21 | Rebuilt parallel word |
| strobe_o | output | 1 | Output strobe; its rising edge marks valid data |

## Verification
The case where two functions meet in one cycle is power-down and a frame edge. In that same cycle the pipeline would otherwise capture a new frame and load the output register. The bench lowers pwr_on_n_i at the very moment it raises the frame clock for the fifth frame of a running burst. It then requires word_o and strobe_o to be low once that frame has been sent, and it requires that none of the queued words is ever strobed. A second pairing pits a long frame period against the loss counter. Periods of 16 and 17 cycles are sent back to back so that the boundary on each side is checked.

// File: rtl/tld_pkg.sv
package tld_pkg;
  localparam int unsigned LANES_DEF = 3;
  localparam int unsigned BITS_DEF  = 7;
  localparam int unsigned LOSS_DEF  = 16;
endpackage

// File: rtl/tld_frame_tracker.sv
module tld_frame_tracker #(
  parameter int unsigned BITS = 7,
  parameter int unsigned LOSS = 16,
  localparam int unsigned CW = $clog2(BITS + 1),
  localparam int unsigned GW = $clog2(LOSS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_clk_i,
  input  logic          pwr_on_n_i,
  output logic          edge_o,
  output logic          sample_o,
  output logic [CW-1:0] idx_o,
  output logic          complete_o,
  output logic          lost_o
);
  logic          fclk_q;
  logic [CW-1:0] pos_r;
  logic [GW-1:0] gap_r;
  logic          armed_r;
  logic          lost_r;
  logic          gap_full;

  assign edge_o     = frame_clk_i & ~fclk_q;
  assign idx_o      = edge_o ? '0 : pos_r;
  assign sample_o   = edge_o || (pos_r < CW'(BITS));
  assign complete_o = edge_o && armed_r && (pos_r == CW'(BITS));
  assign gap_full   = (gap_r >= GW'(LOSS - 1));
  assign lost_o     = lost_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      fclk_q  <= 1'b0;
      pos_r   <= CW'(BITS);
      gap_r   <= '0;
      armed_r <= 1'b0;
      lost_r  <= 1'b0;
    end else begin
      fclk_q <= frame_clk_i;
      if (edge_o)                  pos_r <= CW'(1);
      else if (pos_r < CW'(BITS))  pos_r <= pos_r + CW'(1);
      if (edge_o)                  gap_r <= '0;
      else if (gap_r != GW'(LOSS)) gap_r <= gap_r + GW'(1);
      if (edge_o)                  lost_r <= 1'b0;
      else if (gap_full)           lost_r <= 1'b1;
      if (!pwr_on_n_i)             armed_r <= 1'b0;
      else if (edge_o)             armed_r <= 1'b1;
      else if (gap_full)           armed_r <= 1'b0;
    end
  end

  // R7: a frame edge ends any loss condition
  a_r7_edge_clears_loss: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !lost_o);
  // R2: the sample after the edge is sample 1
  a_r2_second_sample: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (idx_o == CW'(1)));
endmodule

// File: rtl/tld_lane_capture.sv
module tld_lane_capture #(
  parameter int unsigned BITS = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_i,
  input  logic            bit_i,
  output logic [BITS-1:0] bits_o
);
  logic [BITS-1:0] sr_r;

  always_ff @(posedge clk) begin
    if (rst)           sr_r <= '0;
    else if (sample_i) sr_r <= {bit_i, sr_r[BITS-1:1]};
  end

  assign bits_o = sr_r;

  // R1: the newest sample enters at the top and moves toward bit 0
  a_r1_newest_bit: assert property (@(posedge clk) disable iff (rst)
    sample_i |=> (bits_o[BITS-1] == $past(bit_i)));
endmodule

// File: rtl/tld_word_pipe.sv
module tld_word_pipe #(
  parameter int unsigned W    = 21,
  parameter int unsigned BITS = 7,
  localparam int unsigned CW     = $clog2(BITS + 1),
  localparam int unsigned STB_LO = BITS / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_on_n_i,
  input  logic          edge_i,
  input  logic          complete_i,
  input  logic          lost_i,
  input  logic [CW-1:0] idx_i,
  input  logic [W-1:0]  cap_i,
  output logic [W-1:0]  word_o,
  output logic          strobe_o
);
  logic [W-1:0] stage_r;
  logic         stage_v;
  logic         en_r;
  logic [W-1:0] word_r;
  logic         stb_r;

  always_ff @(posedge clk) begin
    if (rst || !pwr_on_n_i) begin
      stage_r <= '0;
      stage_v <= 1'b0;
      en_r    <= 1'b0;
      word_r  <= '0;
      stb_r   <= 1'b0;
    end else begin
      if (lost_i) begin
        stage_v <= 1'b0;
        en_r    <= 1'b0;
      end else if (edge_i) begin
        stage_r <= cap_i;
        stage_v <= complete_i;
        if (stage_v) begin
          word_r <= stage_r;
          en_r   <= 1'b1;
        end
      end
      stb_r <= en_r && !lost_i && !edge_i &&
               (idx_i >= CW'(STB_LO)) && (idx_i < CW'(BITS));
    end
  end

  assign word_o   = word_r;
  assign strobe_o = stb_r;

  // R5: power-down clears the word and the strobe
  a_r5_pd_clears: assert property (@(posedge clk) disable iff (rst)
    !pwr_on_n_i |=> (word_o == '0 && !strobe_o));
  // R7: while the clock is lost, the word is held
  a_r7_loss_hold: assert property (@(posedge clk) disable iff (rst)
    (lost_i && pwr_on_n_i) |=> $stable(word_o));
  // R3: the word does not change while the strobe is high
  a_r3_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $stable(word_o));
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser #(
  parameter int unsigned LANES = tld_pkg::LANES_DEF,
  parameter int unsigned BITS  = tld_pkg::BITS_DEF,
  parameter int unsigned LOSS  = tld_pkg::LOSS_DEF,
  localparam int unsigned W  = LANES * BITS,
  localparam int unsigned CW = $clog2(BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_clk_i,
  input  logic [LANES-1:0] lane_i,
  input  logic             pwr_on_n_i,
  output logic [W-1:0]     word_o,
  output logic             strobe_o
);
  logic          edge_w;
  logic          sample_w;
  logic [CW-1:0] idx_w;
  logic          complete_w;
  logic          lost_w;
  logic [W-1:0]  cap_w;

  tld_frame_tracker #(.BITS(BITS), .LOSS(LOSS)) trk_i (
    .clk(clk), .rst(rst), .frame_clk_i(frame_clk_i), .pwr_on_n_i(pwr_on_n_i),
    .edge_o(edge_w), .sample_o(sample_w), .idx_o(idx_w),
    .complete_o(complete_w), .lost_o(lost_w)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tld_lane_capture #(.BITS(BITS)) cap_i (
      .clk(clk), .rst(rst), .sample_i(sample_w), .bit_i(lane_i[l]),
      .bits_o(cap_w[l*BITS +: BITS])
    );
  end

  tld_word_pipe #(.W(W), .BITS(BITS)) pipe_i (
    .clk(clk), .rst(rst), .pwr_on_n_i(pwr_on_n_i), .edge_i(edge_w),
    .complete_i(complete_w), .lost_i(lost_w), .idx_i(idx_w), .cap_i(cap_w),
    .word_o(word_o), .strobe_o(strobe_o)
  );
endmodule

// File: tb/tri_lane_deser_tb_top.sv
module tri_lane_deser_tb_top;
  localparam int LN = 3;
  localparam int NB = 7;
  localparam int WW = LN * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fclk = 1'b0;
  logic [LN-1:0] lanes = '1;
  logic          pwr_n = 1'b1;
  logic [WW-1:0] word;
  logic          strobe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [WW-1:0] last_ok = '0;
  logic stb_prev = 1'b0;

  typedef struct {
    logic [WW-1:0] w;
    int            stamp;
    bit            lat;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_lane_deser dut_i (
    .clk(clk), .rst(rst), .frame_clk_i(fclk), .lane_i(lanes),
    .pwr_on_n_i(pwr_n), .word_o(word), .strobe_o(strobe)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one frame; lanes idle high in any stretch cycles (R2, R9)
  task automatic send_frame(input logic [WW-1:0] w, input int extra, input bit push, input bit lat);
    for (int i = 0; i < NB + extra; i++) begin
      fclk = (i < 4);
      for (int l = 0; l < LN; l++) lanes[l] = (i < NB) ? w[l*NB + i] : 1'b1;
      if (i == 0 && push) q.push_back('{w, cyc + 1, lat});
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    fclk = 1'b0;
    lanes = '1;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // n frames; the last two never reach the output once the clock stops
  task automatic burst(input int n, input bit ones);
    for (int k = 0; k < n; k++) begin
      logic [WW-1:0] w;
      w = ones ? '1 : WW'($urandom);
      send_frame(w, 0, k < n - 2, 1'b1);
    end
    idle(30);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (strobe && !stb_prev) begin
        if (q.size() == 0) begin
          check_eq("R8 no unexpected strobe", {11'd0, word}, 32'hFFFF_FFFF);
        end else begin
          item_t it;
          it = q.pop_front();
          check_eq("R1 word", {11'd0, word}, {11'd0, it.w});
          if (it.lat) check_eq("R4 latency", cyc - it.stamp, 17);
          last_ok = it.w;
        end
      end
      stb_prev = strobe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check_eq("R10 reset word", {11'd0, word}, 0);
    check_eq("R10 reset strobe", {31'd0, strobe}, 0);
    rst = 1'b0;
    idle(20);

    // R1 R4: random words
    burst(8, 1'b0);
    check_eq("R4 all delivered", q.size(), 0);
    check_eq("R7 hold after clock stop", {11'd0, word}, {11'd0, last_ok});
    check_eq("R7 strobe low after stop", {31'd0, strobe}, 0);

    // R1: walking single bits across lane boundaries
    begin
      int pos[6] = '{0, 6, 7, 13, 14, 20};
      foreach (pos[j]) send_frame(WW'(1) << pos[j], 0, 1'b1, 1'b1);
      send_frame('0, 0, 1'b0, 1'b1);
      send_frame('0, 0, 1'b0, 1'b1);
      idle(30);
      check_eq("R1 walking bits delivered", q.size(), 0);
    end

    // R9: lanes idle high with a running frame clock
    burst(5, 1'b1);
    check_eq("R9 all ones", {11'd0, word}, {11'd0, {WW{1'b1}}});

    // R7 R2: period of 16 keeps every frame, stretch bits ignored
    for (int k = 0; k < 6; k++) send_frame(WW'($urandom), (k == 2) ? 9 : 0, k < 4, 1'b0);
    idle(30);
    check_eq("R7 period 16 no loss", q.size(), 0);

    // R7 R8: period of 17 is a loss; restart afterwards
    begin
      logic [WW-1:0] f0;
      f0 = WW'($urandom);
      send_frame(f0, 0, 1'b1, 1'b1);
      send_frame(WW'($urandom), 0, 1'b0, 1'b0);
      send_frame(WW'($urandom), 10, 1'b0, 1'b0);
      check_eq("R7 hold during loss", {11'd0, word}, {11'd0, f0});
      check_eq("R7 strobe low during loss", {31'd0, strobe}, 0);
      send_frame(WW'($urandom), 0, 1'b1, 1'b1);
      send_frame(WW'($urandom), 0, 1'b0, 1'b0);
      send_frame(WW'($urandom), 0, 1'b0, 1'b0);
      idle(30);
      check_eq("R8 resume delivered", q.size(), 0);
    end

    // R5 R6: power-down and power-on warm-up
    pwr_n = 1'b0;
    idle(10);
    check_eq("R5 pd word", {11'd0, word}, 0);
    check_eq("R5 pd strobe", {31'd0, strobe}, 0);
    pwr_n = 1'b1;
    send_frame(WW'($urandom), 0, 1'b1, 1'b1);
    send_frame(WW'($urandom), 0, 1'b1, 1'b1);
    check_eq("R6 word low before two frames", {11'd0, word}, 0);
    check_eq("R6 strobe low before two frames", {31'd0, strobe}, 0);
    send_frame(WW'($urandom), 0, 1'b1, 1'b1);
    send_frame(WW'($urandom), 0, 1'b0, 1'b1);
    send_frame(WW'($urandom), 0, 1'b0, 1'b1);
    idle(30);
    check_eq("R6 warm-up delivered", q.size(), 0);

    // R5: power-down in the same cycle as a frame edge
    for (int k = 0; k < 4; k++) send_frame(WW'($urandom), 0, 1'b1, 1'b1);
    pwr_n = 1'b0;
    q.delete();
    send_frame(WW'($urandom), 0, 1'b0, 1'b0);
    check_eq("R5 pd at edge word", {11'd0, word}, 0);
    check_eq("R5 pd at edge strobe", {31'd0, strobe}, 0);
    send_frame(WW'($urandom), 0, 1'b0, 1'b0);
    pwr_n = 1'b1;
    idle(30);
    check_eq("R6 nothing after pd", {11'd0, word}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule